// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block is the device-side part of a small byte-wide flash array model. It answers status polls while a program or sector-erase operation runs inside the device. A command port starts an operation. A program command carries an address and a data byte. An erase command carries an address whose upper bits select a sector. While the operation runs, a read of the affected location does not return stored data. It returns a status byte instead. In that byte, bit 6 inverts on every read access, and bit 5 reports a failure.

Host firmware polls the location until two reads in a row agree on bit 6. It then checks bit 5 to tell a clean completion from a failed one. A failure has two causes: the operation timer expires, or a program command asks to turn a stored 0 back into a 1. After a clean completion, reads return the array contents again. After a failure, the status byte stays frozen, with bit 5 at 1, until the next command is accepted.

Top module: `flash_status_responder`

## Requirements
- R1: After reset, `busy` is 0 and every address reads 0xFF, which is the erased value.
- R2: A program command (`cmd_erase`=0) holds `busy` high for exactly PROG_CYC cycles. After that, the byte at `cmd_addr` equals its old value ANDed with `cmd_data`.
- R3: While a program runs, a read of the byte being programmed returns a status byte. In that byte, bits 7 and 4..0 are 0, bit 5 is the error flag, and bit 6 inverts between one read and the next.
- R4: While an operation runs, a read of an address outside the active byte (program) or outside the active sector (erase) returns the stored array data.
- R5: An erase command (`cmd_erase`=1) holds `busy` high for ERASE_CYC cycles. It then sets every byte whose upper SECT_W address bits match those of `cmd_addr` to 0xFF. During the erase, reads anywhere in that sector return the toggling status byte.
- R6: A program whose data has a 1 in a bit position where the stored byte holds 0 sets bit 5 from the first status read onward. It leaves the array unchanged. Bit 6 keeps toggling until `busy` drops, which happens TIMEOUT_CYC cycles after the command was accepted.
- R7: An operation whose length exceeds TIMEOUT_CYC ends after TIMEOUT_CYC cycles with bit 5 set, and the array is not written.
- R8: A command presented while `busy` is 1 is ignored. It neither changes the array nor extends the running operation.
- R9: After a failure, reads of the failed location return a status byte with bit 5 at 1 and bit 6 constant. The next accepted command clears this state.
- R10: The toggle bit advances only on read accesses to the active location, not on clock cycles. Two polls separated by idle cycles still differ in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_erase | input | 1 | 1 = sector erase, 0 = byte program |
| cmd_addr | input | ADDR_W | Target byte, or any byte in the target sector |
| cmd_data | input | 8 | Data byte for a program |
| rd_en | input | 1 | Read access strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, valid the cycle after `rd_en` |
| busy | output | 1 | Embedded operation in progress |

## Verification
The hardest case to reach is the frozen failure state. In that state, bit 6 must stop while bit 5 stays set, and the array must still hold its old value. That value can only be seen once a later command has released the location. The stimulus first programs a byte to 0x00 and then asks for 0x01, which makes the failure certain. It polls through and past the timeout, then issues an unrelated program and reads the byte back. The timeout path for erase is reached by a second instance whose timeout is shorter than its erase time, driven from the same stimulus.

// File: rtl/flash_sr_pkg.sv
// Package: shared constants and the status-byte builder for the flash
// status responder. Assumes a byte-wide array.
package flash_sr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FAIL = 2'd2
    } sr_state_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // Status byte: bit 6 toggle, bit 5 error, all other bits zero.
    function automatic logic [7:0] status_byte(input logic tgl, input logic err);
        return {1'b0, tgl, err, 5'b00000};
    endfunction

endpackage

// File: rtl/flash_sr_array.sv
// Module: byte array of the flash model. A program ANDs data into one byte;
// an erase writes 0xFF to every byte of one sector (upper SECT_W address
// bits). Assumes program and erase strobes are never high together.
module flash_sr_array #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic              erase_we,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        rd_byte,
    output logic [7:0]        chk_byte
);
    import flash_sr_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // Reset to the erased state, then apply program or sector erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
        end else if (erase_we) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ADDR_W'(i) >> (ADDR_W - SECT_W) == op_addr >> (ADDR_W - SECT_W))
                    mem_q[i] <= ERASED_BYTE;
            end
        end else if (prog_we) begin
            mem_q[op_addr] <= mem_q[op_addr] & op_data;
        end
    end

    // Two combinational read ports: host read and command legality check.
    always_comb begin
        rd_byte  = mem_q[rd_addr];
        chk_byte = mem_q[chk_addr];
    end

endmodule

// File: rtl/flash_sr_seq.sv
// Module: operation sequencer. Accepts a command when not running, counts
// its duration, detects illegal 0->1 programs and timeouts, and keeps the
// toggle bit that advances on each status read. Assumes PROG_CYC, ERASE_CYC
// and TIMEOUT_CYC are all at least 1.
module flash_sr_seq #(
    parameter int ADDR_W      = 6,
    parameter int SECT_W      = 2,
    parameter int PROG_CYC    = 6,
    parameter int ERASE_CYC   = 12,
    parameter int TIMEOUT_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [7:0]        cur_byte,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              prog_we,
    output logic              erase_we,
    output logic [ADDR_W-1:0] act_addr,
    output logic [7:0]        act_data,
    output logic              hit,
    output logic              tgl,
    output logic              err
);
    import flash_sr_pkg::*;

    localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_C = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(TIMEOUT_CYC - 1);

    sr_state_t         state_q;
    logic              erase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept, finish, expire;

    // Decode acceptance, clean completion and timer expiry.
    always_comb begin
        accept = cmd_valid && (state_q != ST_RUN);
        finish = (state_q == ST_RUN) && !err &&
                 (cnt_q == (erase_q ? ERASE_LAST : PROG_LAST));
        expire = (state_q == ST_RUN) && !finish && (cnt_q == TMO_LAST);
    end

    // Operation state, captured command fields, counter and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            erase_q  <= 1'b0;
            act_addr <= '0;
            act_data <= '0;
            cnt_q    <= '0;
            err      <= 1'b0;
        end else if (accept) begin
            state_q  <= ST_RUN;
            erase_q  <= cmd_erase;
            act_addr <= cmd_addr;
            act_data <= cmd_data;
            cnt_q    <= '0;
            err      <= !cmd_erase && ((cmd_data & ~cur_byte) != 8'h00);
        end else if (finish) begin
            state_q <= ST_IDLE;
        end else if (expire) begin
            state_q <= ST_FAIL;
            err     <= 1'b1;
        end else if (state_q == ST_RUN) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Toggle bit advances on each read of the active region while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                                tgl <= 1'b0;
        else if (rd_en && hit && state_q == ST_RUN) tgl <= ~tgl;
    end

    // Address match against the active byte or sector; write strobes.
    always_comb begin
        if (state_q == ST_IDLE)
            hit = 1'b0;
        else if (erase_q)
            hit = (rd_addr >> (ADDR_W - SECT_W)) == (act_addr >> (ADDR_W - SECT_W));
        else
            hit = (rd_addr == act_addr);
        busy     = (state_q == ST_RUN);
        prog_we  = finish && !erase_q;
        erase_we = finish && erase_q;
    end

endmodule

// File: rtl/flash_sr_rdmux.sv
// Module: registered read port. Returns the status byte when the read hits
// the active region, otherwise the array byte. Holds its value between reads.
module flash_sr_rdmux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       hit,
    input  logic       tgl,
    input  logic       err,
    input  logic [7:0] arr_byte,
    output logic [7:0] rd_data
);
    import flash_sr_pkg::*;

    // Capture status or array data on each read access.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= hit ? status_byte(tgl, err) : arr_byte;
    end

endmodule

// File: rtl/flash_status_responder.sv
// Module: top of the flash status responder. Connects the sequencer, the
// byte array and the read multiplexer. Assumes SECT_W < ADDR_W.
module flash_status_responder #(
    parameter int ADDR_W      = 6,
    parameter int SECT_W      = 2,
    parameter int PROG_CYC    = 6,
    parameter int ERASE_CYC   = 12,
    parameter int TIMEOUT_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic              prog_we, erase_we, hit, tgl, err;
    logic [ADDR_W-1:0] act_addr;
    logic [7:0]        act_data, arr_byte, cur_byte;

    flash_sr_seq #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cur_byte(cur_byte),
        .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .prog_we(prog_we),
        .erase_we(erase_we), .act_addr(act_addr), .act_data(act_data),
        .hit(hit), .tgl(tgl), .err(err)
    );

    flash_sr_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .erase_we(erase_we),
        .op_addr(act_addr), .op_data(act_data), .rd_addr(rd_addr),
        .chk_addr(cmd_addr), .rd_byte(arr_byte), .chk_byte(cur_byte)
    );

    flash_sr_rdmux u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(hit), .tgl(tgl),
        .err(err), .arr_byte(arr_byte), .rd_data(rd_data)
    );

endmodule

// File: rtl/flash_sr_chk.sv
// Module: assertion checker for the flash status responder, bound to the top.
module flash_sr_chk #(
    parameter int ADDR_W      = 6,
    parameter int TIMEOUT_CYC = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cmd_valid,
    input logic              rd_en,
    input logic              hit,
    input logic              tgl,
    input logic              err,
    input logic              prog_we,
    input logic [ADDR_W-1:0] act_addr
);
    localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);

    logic [RUN_W-1:0] run_len;

    // Count consecutive busy cycles for the timeout bound.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !busy);

    // R10
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && hit) |=> $stable(tgl));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(act_addr));

    // R2
    write_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> busy);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !busy && !cmd_valid) |=> err);

    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RUN_W'(TIMEOUT_CYC)));

endmodule

bind flash_status_responder flash_sr_chk #(
    .ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid),
    .rd_en(rd_en), .hit(hit), .tgl(tgl), .err(err),
    .prog_we(prog_we), .act_addr(act_addr)
);

// File: tb/flash_status_responder_tb.sv
module flash_status_responder_tb;
    localparam int AW = 6, SW = 2, PC = 6, EC = 12, TC = 20, TC2 = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SECT = 1 << (AW - SW);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_erase = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic [7:0] rd_data, rd_data2;
    logic busy, busy2;

    int checks = 0, errors = 0;
    int run_cnt = 0, last_run = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    flash_status_responder #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC),
        .ERASE_CYC(EC), .TIMEOUT_CYC(TC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

    flash_status_responder #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC),
        .ERASE_CYC(EC), .TIMEOUT_CYC(TC2)) u_dut_to (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data2), .busy(busy2));

    // Length of the last busy run of u_dut.
    always @(posedge clk) begin
        if (busy) run_cnt = run_cnt + 1;
        else if (run_cnt != 0) begin last_run = run_cnt; run_cnt = 0; end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic er, input int a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = er; cmd_addr = AW'(a); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v, output logic [7:0] v2);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0; v = rd_data; v2 = rd_data2;
    endtask

    task automatic wait_idle();
        while (busy || busy2) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] v, w, x, y;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", busy, 0);
        for (int i = 0; i < DEPTH; i++) begin rd(i, v, w); check("R1 erased", v, 8'hFF); end

        // R2/R3/R4: program sweep over sector 0
        for (int a = 0; a < SECT; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 11) ^ 8'hA5);
            issue(1'b0, a, d);
            rd(a, v, w); rd(a, x, w);
            check("R3 status bits", v & 8'h9F, 0);
            check("R3 err clear", (v >> 5) & 1, 0);
            check("R3 toggle", (v ^ x) & 8'h40, 8'h40);
            rd(a + SECT, y, w);
            check("R4 outside", y, model[a + SECT]);
            wait_idle();
            check("R2 busy length", last_run, PC);
            model[a] = model[a] & d;
            rd(a, v, w);
            check("R2 and result", v, model[a]);
        end
        // R2: second legal program of a subset
        issue(1'b0, 3, model[3] & 8'h0F);
        wait_idle();
        model[3] = model[3] & 8'h0F;
        rd(3, v, w);
        check("R2 subset", v, model[3]);

        // R5/R8/R10: erase sector 0 with a command while busy
        issue(1'b1, 5, 8'h00);
        rd(9, v, w);
        repeat (3) @(negedge clk);
        rd(14, x, w);
        check("R10 toggle across idle", (v ^ x) & 8'h40, 8'h40);
        check("R5 status in sector", v & 8'hBF, 0);
        rd(SECT + 2, y, w);
        check("R4 other sector", y, model[SECT + 2]);
        issue(1'b0, 2 * SECT + 1, 8'h00);
        wait_idle();
        check("R5 erase length", last_run, EC);
        for (int a = 0; a < SECT; a++) model[a] = 8'hFF;
        for (int a = 0; a < DEPTH; a++) begin rd(a, v, w); check("R5 R8 array", v, model[a]); end

        // R6/R9: illegal 0->1 program
        issue(1'b0, 7, 8'h00);
        wait_idle();
        model[7] = 8'h00;
        issue(1'b0, 7, 8'h01);
        rd(7, v, w); rd(7, x, w);
        check("R6 err bit", v & 8'hBF, 8'h20);
        check("R6 toggle", (v ^ x) & 8'h40, 8'h40);
        wait_idle();
        check("R6 timeout length", last_run, TC);
        rd(7, v, w); rd(7, x, w);
        check("R9 err held", (v >> 5) & 1, 1);
        check("R9 toggle frozen", v, x);
        issue(1'b0, 8, 8'hFE);
        wait_idle();
        model[8] = 8'hFE;
        rd(7, v, w);
        check("R9 cleared, R6 unchanged", v, 8'h00);

        // R7: erase timeout on the short-timeout instance
        issue(1'b0, SECT + 4, 8'h5A);
        wait_idle();
        model[SECT + 4] = 8'h5A;
        issue(1'b1, SECT, 8'h00);
        repeat (TC2 + 2) @(negedge clk);
        check("R7 busy dropped", busy2, 0);
        rd(SECT + 4, v, w);
        check("R7 err bit", w & 8'hBF, 8'h20);
        wait_idle();
        issue(1'b0, 9, 8'hFF);
        wait_idle();
        rd(SECT + 4, v, w);
        check("R7 array kept", w, 8'h5A);
        check("R5 erased on long timeout", v, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule